// File: doc/BRIEF.md
# Request-Triggered Burst DMA Channel

This block is a single DMA channel that copies a programmed number of 32-bit words from a source address to a destination address over a simple request/ready memory bus. Software first writes the source and destination addresses, the transfer size in bytes and a control word. The control word holds the burst length, a source-increment bit and the enable bit. Once enabled, the channel sits armed and does nothing on the bus until a peripheral raises its request line.

On that request the channel asks for the bus and holds it for the whole transfer. It works one burst at a time: it reads a burst of words into an internal FIFO, then writes the full burst out to incrementing destination addresses. It repeats this until the word count is used up. The source address can stay fixed, which suits a peripheral data register, or step by four per word, which suits a memory buffer. At the end the channel drops the bus, clears its own enable and raises a done flag and a level interrupt. Writing 1 to the status register clears both. Another transfer needs the control word to be written again.

Top module: `dma_channel`

## Requirements
- R1: After reset, `bus_req`, `m_valid`, `done` and `irq` are all 0.
- R2: An enabled channel leaves `bus_req` and `m_valid` low until `dreq` is high. After `bus_req` rises, `m_valid` is asserted only while `bus_gnt` is high.
- R3: `bus_req` stays high without a gap from its rise until the last write of the transfer has completed, and it falls exactly once per transfer.
- R4: Each burst of `b` words is exactly `b` reads followed by `b` writes. The writes carry the read data in read order. The source address is SRC on every read when control bit 4 is 0. When bit 4 is 1, read k goes to SRC + 4k.
- R5: Write k of a transfer goes to DST + 4k, counted across all bursts.
- R6: The transfer moves TOTAL/4 words (TOTAL at register 2, bits 1:0 ignored). The burst length is control bits 3:0 plus 1, so from 1 to 16. The last burst is shorter when fewer words than one burst remain.
- R7: While `m_valid` is high and `m_ready` is low, `m_valid`, `m_write`, `m_addr` and `m_wdata` keep their values into the next cycle.
- R8: At completion `done` and `irq` go to 1 and the channel disables itself. A later `dreq` starts no new transfer until control bit 8 is written to 1 again.
- R9: A write to register 4 with bit 0 set clears `done` and `irq`. A write with bit 0 clear leaves them unchanged.
- R10: Writes to registers 0 to 3 are ignored from enable until completion, so the running transfer keeps the addresses and count it started with.
- R11: A TOTAL of zero completes on request and grant with no data beat on the bus.
- R12: The internal FIFO is never pushed when full nor popped when empty. It holds exactly one burst when writing starts, and it is empty at completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index: 0 SRC, 1 DST, 2 TOTAL bytes, 3 control, 4 status |
| cfg_wdata | input | 32 | Register write data |
| dreq | input | 1 | Peripheral transfer request |
| bus_req | output | 1 | Bus ownership request, held for the whole transfer |
| bus_gnt | input | 1 | Bus ownership grant |
| m_valid | output | 1 | Memory access valid |
| m_write | output | 1 | 1 = write, 0 = read |
| m_addr | output | AW | Byte address of the access |
| m_wdata | output | DW | Write data |
| m_ready | input | 1 | Access completes on a clock edge where valid and ready are both high |
| m_rdata | input | DW | Read data, valid in the cycle where ready is high |
| done | output | 1 | Transfer-complete flag |
| irq | output | 1 | Level interrupt, follows `done` |

## Verification
Random transfers vary the burst length (1 to 16), the word count, the source-increment bit, the grant latency and the rate of ready stalls. Each transfer's full bus log is compared with the expected read-then-write sequence. A word count that is not a multiple of the burst shows whether the short final burst is handled. Fixed and incrementing sources show whether the address step follows the control bit. Stalls show whether requests are held steady. Directed cases cover a 512-byte transfer with 16-word bursts, single-word bursts, a zero total, register writes during a live transfer, and a second request after completion, which tells a self-disabling channel from one that re-arms.

// File: rtl/dma_pkg.sv
`timescale 1ns/1ps
package dma_pkg;
  localparam int WORD_BYTES = 4;

  localparam logic [2:0] REG_SRC    = 3'd0;
  localparam logic [2:0] REG_DST    = 3'd1;
  localparam logic [2:0] REG_TOTAL  = 3'd2;
  localparam logic [2:0] REG_CTRL   = 3'd3;
  localparam logic [2:0] REG_STATUS = 3'd4;

  localparam int CTRL_INC_BIT = 4;
  localparam int CTRL_EN_BIT  = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ARM, ST_GRANT, ST_READ, ST_WRITE, ST_FIN
  } dma_state_t;
endpackage

// File: rtl/dma_fifo.sv
`timescale 1ns/1ps
module dma_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic          full,
  output logic          empty,
  output logic [LW-1:0] level
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr, rptr;

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (level == LW'(DEPTH));
  assign empty = (level == '0);
  assign dout  = mem[rptr];

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (push) wptr <= wrap_inc(wptr);
      if (pop)  rptr <= wrap_inc(rptr);
      case ({push, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  p_no_overflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push);
  p_no_underflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !pop);
endmodule

// File: rtl/dma_cfg_regs.sv
`timescale 1ns/1ps
module dma_cfg_regs
  import dma_pkg::*;
#(
  parameter int AW   = 32,
  parameter int CW   = 16,
  parameter int MAXB = 16,
  localparam int FBW = $clog2(MAXB),
  localparam int BLW = FBW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [2:0]    addr,
  input  logic [31:0]   wdata,
  input  logic          busy,
  input  logic          fin,
  output logic [AW-1:0] src,
  output logic [AW-1:0] dst,
  output logic [CW-1:0] words,
  output logic [BLW-1:0] blen,
  output logic          src_inc,
  output logic          enable,
  output logic          done
);
  logic cfg_open;
  logic clr_hit;

  function automatic logic [BLW-1:0] decode_blen(input logic [31:0] d);
    return BLW'(d[FBW-1:0]) + 1'b1;
  endfunction

  assign cfg_open = we && !busy;
  assign clr_hit  = we && (addr == REG_STATUS) && wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src <= '0; dst <= '0; words <= '0; blen <= BLW'(1);
      src_inc <= 1'b0; enable <= 1'b0; done <= 1'b0;
    end else begin
      if (cfg_open) begin
        case (addr)
          REG_SRC:   src   <= AW'(wdata);
          REG_DST:   dst   <= AW'(wdata);
          REG_TOTAL: words <= wdata[CW+1:2];
          REG_CTRL: begin
            blen    <= decode_blen(wdata);
            src_inc <= wdata[CTRL_INC_BIT];
          end
          default: ;
        endcase
      end
      if (fin) enable <= 1'b0;
      else if (cfg_open && addr == REG_CTRL) enable <= wdata[CTRL_EN_BIT];
      if (fin) done <= 1'b1;
      else if (clr_hit) done <= 1'b0;
    end
  end

  p_fin_disables_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> (done && !enable));
  p_busy_dst_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && we && addr == REG_DST) |=> $stable(dst));
  p_clear_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit && !fin) |=> !done);
endmodule

// File: rtl/dma_ctrl.sv
`timescale 1ns/1ps
module dma_ctrl
  import dma_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int CW   = 16,
  parameter int MAXB = 16,
  localparam int BLW = $clog2(MAXB) + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           enable,
  input  logic [AW-1:0]  cfg_src,
  input  logic [AW-1:0]  cfg_dst,
  input  logic [CW-1:0]  cfg_words,
  input  logic [BLW-1:0] cfg_blen,
  input  logic           cfg_src_inc,
  input  logic           dreq,
  input  logic           bus_gnt,
  input  logic           m_ready,
  input  logic [DW-1:0]  fifo_dout,
  output logic           bus_req,
  output logic           m_valid,
  output logic           m_write,
  output logic [AW-1:0]  m_addr,
  output logic [DW-1:0]  m_wdata,
  output logic           fifo_push,
  output logic           fifo_pop,
  output logic           fin,
  output logic           busy,
  output logic [BLW-1:0] burst_take
);
  dma_state_t     state;
  logic [AW-1:0]  src_cur, dst_cur;
  logic [CW-1:0]  remain, remain_after;
  logic [BLW-1:0] blen_l, beat;
  logic           inc_l;
  logic           rd_fire, wr_fire, last_beat;

  function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] a, input logic inc);
    return inc ? a + AW'(WORD_BYTES) : a;
  endfunction

  function automatic logic [BLW-1:0] chunk(input logic [CW-1:0] rem, input logic [BLW-1:0] bl);
    return (rem < CW'(bl)) ? BLW'(rem) : bl;
  endfunction

  assign busy         = (state != ST_IDLE);
  assign bus_req      = (state == ST_GRANT) || (state == ST_READ) || (state == ST_WRITE);
  assign m_valid      = (state == ST_READ) || (state == ST_WRITE);
  assign m_write      = (state == ST_WRITE);
  assign m_addr       = m_write ? dst_cur : src_cur;
  assign m_wdata      = fifo_dout;
  assign rd_fire      = (state == ST_READ) && m_ready;
  assign wr_fire      = (state == ST_WRITE) && m_ready;
  assign fifo_push    = rd_fire;
  assign fifo_pop     = wr_fire;
  assign fin          = (state == ST_FIN);
  assign last_beat    = (BLW'(beat + 1'b1) == burst_take);
  assign remain_after = remain - CW'(burst_take);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; src_cur <= '0; dst_cur <= '0; remain <= '0;
      blen_l <= BLW'(1); inc_l <= 1'b0; beat <= '0; burst_take <= '0;
    end else begin
      case (state)
        ST_IDLE: if (enable) begin
          state   <= ST_ARM;
          src_cur <= cfg_src;
          dst_cur <= cfg_dst;
          remain  <= cfg_words;
          blen_l  <= cfg_blen;
          inc_l   <= cfg_src_inc;
        end
        ST_ARM: if (dreq) state <= ST_GRANT;
        ST_GRANT: if (bus_gnt) begin
          if (remain == '0) state <= ST_FIN;
          else begin
            state      <= ST_READ;
            burst_take <= chunk(remain, blen_l);
            beat       <= '0;
          end
        end
        ST_READ: if (rd_fire) begin
          src_cur <= step_addr(src_cur, inc_l);
          if (last_beat) begin
            state <= ST_WRITE;
            beat  <= '0;
          end else beat <= beat + 1'b1;
        end
        ST_WRITE: if (wr_fire) begin
          dst_cur <= step_addr(dst_cur, 1'b1);
          if (last_beat) begin
            remain <= remain_after;
            beat   <= '0;
            if (remain_after == '0) state <= ST_FIN;
            else begin
              state      <= ST_READ;
              burst_take <= chunk(remain_after, blen_l);
            end
          end else beat <= beat + 1'b1;
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_hold_stalled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_write) && $stable(m_addr) && $stable(m_wdata)));
  p_req_needs_dreq_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> $past(dreq));
  p_release_at_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_req) |-> fin);
  p_valid_with_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_valid) |-> $past(bus_gnt));
endmodule

// File: rtl/dma_channel.sv
`timescale 1ns/1ps
module dma_channel
  import dma_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int CW   = 16,
  parameter int MAXB = 16,
  localparam int BLW = $clog2(MAXB) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [31:0]   cfg_wdata,
  input  logic          dreq,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic          m_valid,
  output logic          m_write,
  output logic [AW-1:0] m_addr,
  output logic [DW-1:0] m_wdata,
  input  logic          m_ready,
  input  logic [DW-1:0] m_rdata,
  output logic          done,
  output logic          irq
);
  logic [AW-1:0]  r_src, r_dst;
  logic [CW-1:0]  r_words;
  logic [BLW-1:0] r_blen, take;
  logic           r_inc, r_en, busy, fin;
  logic           f_push, f_pop, f_full, f_empty;
  logic [DW-1:0]  f_dout;
  logic [BLW-1:0] f_level;

  dma_cfg_regs #(.AW(AW), .CW(CW), .MAXB(MAXB)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .busy(busy), .fin(fin), .src(r_src), .dst(r_dst), .words(r_words),
    .blen(r_blen), .src_inc(r_inc), .enable(r_en), .done(done)
  );

  dma_ctrl #(.AW(AW), .DW(DW), .CW(CW), .MAXB(MAXB)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(r_en), .cfg_src(r_src), .cfg_dst(r_dst),
    .cfg_words(r_words), .cfg_blen(r_blen), .cfg_src_inc(r_inc), .dreq(dreq),
    .bus_gnt(bus_gnt), .m_ready(m_ready), .fifo_dout(f_dout), .bus_req(bus_req),
    .m_valid(m_valid), .m_write(m_write), .m_addr(m_addr), .m_wdata(m_wdata),
    .fifo_push(f_push), .fifo_pop(f_pop), .fin(fin), .busy(busy), .burst_take(take)
  );

  dma_fifo #(.DW(DW), .DEPTH(MAXB)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(f_push), .din(m_rdata), .pop(f_pop),
    .dout(f_dout), .full(f_full), .empty(f_empty), .level(f_level)
  );

  assign irq = done;

  p_full_burst_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_write) |-> (f_level == take));
  p_drained_at_end_r12: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> f_empty);
  p_take_bounded_r6: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> (take != '0 && take <= r_blen && !f_full || m_write));
endmodule

// File: tb/dma_channel_test.sv
`timescale 1ns/1ps
module dma_channel_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        dreq = 1'b0;
  logic        bus_req, bus_gnt = 1'b0;
  logic        m_valid, m_write, m_ready = 1'b0;
  logic [31:0] m_addr, m_wdata, m_rdata = '0;
  logic        done, irq;

  dma_channel uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .dreq(dreq), .bus_req(bus_req), .bus_gnt(bus_gnt), .m_valid(m_valid), .m_write(m_write),
    .m_addr(m_addr), .m_wdata(m_wdata), .m_ready(m_ready), .m_rdata(m_rdata),
    .done(done), .irq(irq)
  );

  always #4 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit ended = 0;

  int          n_log, n_rd, falls, n_at_fall, own_err, stall_err;
  int          stall_pct, gnt_lat, gcnt;
  int          kind_q [0:299];
  logic [31:0] addr_q [0:299];
  logic [31:0] data_q [0:299];
  logic [31:0] rd_q   [0:299];
  logic [31:0] rd_seq = 32'h1;

  function automatic logic [31:0] rd_val(input logic [31:0] a, input logic [31:0] s);
    return (a ^ (s * 32'h9E37_79B9)) + 32'h0BAD_0000;
  endfunction

  function automatic int burst_of(input int rem, input int bl);
    return (rem < bl) ? rem : bl;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // bus monitor and memory model: decisions at the falling edge
  initial begin
    bit          pend = 0, pw = 0, pbr = 0;
    logic [31:0] pa = '0, pd = '0;
    forever begin
      @(negedge clk);
      if (pend && (!m_valid || m_write != pw || m_addr != pa || (pw && m_wdata != pd)))
        stall_err++;
      if (bus_req) begin
        gcnt++;
        bus_gnt = (gcnt > gnt_lat);
      end else begin
        gcnt = 0;
        bus_gnt = 1'b0;
      end
      if (pbr && !bus_req) begin
        falls++;
        n_at_fall = n_log;
      end
      pbr = bus_req;
      if (m_valid && !bus_gnt) own_err++;
      m_ready = m_valid && (($urandom % 100) >= stall_pct);
      if (m_valid && !m_write) m_rdata = rd_val(m_addr, rd_seq);
      if (m_valid && m_ready && n_log < 300) begin
        kind_q[n_log] = m_write ? 1 : 0;
        addr_q[n_log] = m_addr;
        data_q[n_log] = m_write ? m_wdata : m_rdata;
        if (!m_write) begin
          rd_q[n_rd] = m_rdata;
          n_rd++;
          rd_seq++;
        end
        n_log++;
      end
      pend = m_valid && !m_ready;
      pw = m_write; pa = m_addr; pd = m_wdata;
    end
  end

  task automatic run_xfer(input logic [31:0] src, input bit inc, input logic [31:0] dst,
                          input int words, input int bl, input int spct, input int glat,
                          input bit poke);
    int pos, ri, wi, rem, tk, t;
    bit ok_ord, ok_src, ok_dst, ok_dat, seen;
    logic [31:0] ea, aa;
    n_log = 0; n_rd = 0; falls = 0; n_at_fall = -1; own_err = 0; stall_err = 0;
    stall_pct = spct; gnt_lat = glat;
    cfg_write(3'd0, src);
    cfg_write(3'd1, dst);
    cfg_write(3'd2, words * 4 + 3);
    cfg_write(3'd3, (32'(bl - 1) & 32'hF) | (32'(inc) << 4) | 32'h100);
    seen = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (bus_req || m_valid) seen = 1;
    end
    check(!seen, "R2", "bus activity before dreq", 32'(seen), 0);
    dreq = 1'b1;
    if (poke) begin
      t = 0;
      while (!m_valid && t < 100) begin @(negedge clk); t++; end
      cfg_write(3'd1, 32'hDEAD_0000);
      cfg_write(3'd2, 32'h4);
      cfg_write(3'd0, 32'hBEEF_0000);
    end
    t = 0;
    while (!done && t < 20000) begin @(negedge clk); t++; end
    check(done && irq, "R8", "done/irq at completion", {30'd0, done, irq}, 32'h3);
    check(!bus_req, "R3", "bus released after completion", 32'(bus_req), 0);
    check(falls == 1 && n_at_fall == 2 * words, "R3", "bus held through all beats",
          32'(n_at_fall), 32'(2 * words));
    check(n_log == 2 * words, words == 0 ? "R11" : "R6", "beat count", 32'(n_log), 32'(2 * words));
    check(own_err == 0 && stall_err == 0, "R7", "stall hold / grant ownership errors",
          32'(own_err + stall_err), 0);
    ok_ord = 1; ok_src = 1; ok_dst = 1; ok_dat = 1;
    pos = 0; ri = 0; wi = 0; rem = words; ea = 0; aa = 0;
    while (rem > 0 && n_log == 2 * words) begin
      tk = burst_of(rem, bl);
      for (int k = 0; k < tk; k++) begin
        if (kind_q[pos] != 0) ok_ord = 0;
        if (addr_q[pos] != (inc ? src + 32'(4 * ri) : src)) begin
          ok_src = 0; ea = inc ? src + 32'(4 * ri) : src; aa = addr_q[pos];
        end
        pos++; ri++;
      end
      for (int k = 0; k < tk; k++) begin
        if (kind_q[pos] != 1) ok_ord = 0;
        if (addr_q[pos] != dst + 32'(4 * wi)) ok_dst = 0;
        if (data_q[pos] != rd_q[wi]) ok_dat = 0;
        pos++; wi++;
      end
      rem -= tk;
    end
    check(ok_ord, "R6", "read-burst/write-burst order", 32'(ok_ord), 1);
    check(ok_src, "R4", "source address", aa, ea);
    check(ok_dst, poke ? "R10" : "R5", "destination address", 32'(ok_dst), 1);
    check(ok_dat, "R4", "write data follows read data", 32'(ok_dat), 1);
    // R8: request again without reprogramming
    seen = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (bus_req || m_valid) seen = 1;
    end
    check(!seen, "R8", "no restart without re-enable", 32'(seen), 0);
    dreq = 1'b0;
    cfg_write(3'd4, 32'h0);
    check(done && irq, "R9", "write 0 keeps done", {30'd0, done, irq}, 32'h3);
    cfg_write(3'd4, 32'h1);
    check(!done && !irq, "R9", "write 1 clears done", {30'd0, done, irq}, 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(!bus_req && !m_valid && !done && !irq, "R1", "reset outputs",
          {28'd0, bus_req, m_valid, done, irq}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!bus_req && !m_valid && !done && !irq, "R1", "outputs after reset release",
          {28'd0, bus_req, m_valid, done, irq}, 0);
    // directed: 512-byte page, fixed source, full 16-word bursts
    run_xfer(32'h4000_0010, 1'b0, 32'h3000_0000, 128, 16, 20, 2, 1'b0);
    // directed: single-word bursts, incrementing source
    run_xfer(32'h1000_0000, 1'b1, 32'h2000_0100, 5, 1, 0, 0, 1'b0);
    // directed: short final burst (R6)
    run_xfer(32'h1000_0400, 1'b1, 32'h2000_0800, 19, 8, 40, 1, 1'b0);
    // directed: zero total (R11)
    run_xfer(32'h1000_0000, 1'b0, 32'h2000_0000, 0, 4, 0, 3, 1'b0);
    // directed: config writes during the transfer are ignored (R10)
    run_xfer(32'h5000_0000, 1'b1, 32'h6000_0000, 24, 6, 30, 1, 1'b1);
    // constrained random
    for (int n = 0; n < 10; n++) begin
      run_xfer({4'h7, 20'($urandom), 8'h00}, 1'($urandom), {4'h8, 20'($urandom), 8'h00},
               1 + int'($urandom % 48), 1 + int'($urandom % 16), int'($urandom % 60),
               int'($urandom % 4), 1'b0);
    end
    ended = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule